// File: doc/BRIEF.md
# I2C Transfer Status Flag Controller

This block keeps two status bits for an I2C peripheral that can work as bus master or as slave. The first is the per-byte pending flag. It stays high while idle and drops low when a byte transfer completes. While it is low, the block asks the bit engine to hold SCL low and to stop generating clocks. Software releases the bus by writing the flag back to 1, by loading new data, or by turning the interface off. The second bit is the transfer direction. A slave that matches its address takes the direction from the master's R/W bit. A set of bus events forces the direction back to receive.

A byte-level engine reports bus events as single-cycle pulses: byte complete, address matched, any address byte, arbitration lost, START, STOP, no-ACK, and START refused by the busy guard. Register writes arrive as single-cycle strobes. The block turns all of these into the flag, a one-cycle interrupt pulse, the SCL hold request and the direction bit. Bit shifting, clock generation and address comparison are done elsewhere.

Top module: `i2c_xfer_flags`

## Requirements
- R1: A `byte_done` or `arb_lost` pulse clears `pend` on the following clock edge, unless a set source is active in the same cycle.
- R2: `scl_hold` is 1 exactly while `pend` is 0. After reset `scl_hold` is 0.
- R3: `pend` becomes 1 after reset and after a `flag_wr` strobe with `flag_wr_val`=1. It is forced to 1 on every edge where `en`=0. A `flag_wr` strobe with `flag_wr_val`=0 leaves `pend` unchanged.
- R4: A `data_wr` strobe sets `pend` to 1 exactly SETTLE_CYCLES (default 8) edges after the edge that samples the strobe. A new `data_wr` restarts the count, and `en`=0 cancels it.
- R5: Slave receive means `is_master`=0 and `dir`=0. In slave receive with `addr_cmp`=1, `addr_match` clears `pend` and `addr_byte` alone does not. With `addr_cmp`=0, `addr_byte` clears `pend`. Address events clear nothing in master mode.
- R6: In slave receive with `addr_cmp`=1, `addr_match` loads `dir` from `rw_bit`: 1 means transmit, 0 means receive.
- R7: `dir` is 0 after reset. On the next edge `dir` becomes 0 after any of these: `arb_lost`, `stop_seen`, `start_blocked`, `start_seen` with `is_master`=0, or `nack_seen` with `is_master`=0. A START or no-ACK in master mode leaves `dir` alone. Clear events win over every other update of `dir`.
- R8: `irq` is high for exactly one cycle. That cycle is the first one in which `pend` reads 0 after having been 1. A clear source while `pend` is already 0 gives no pulse.
- R9: A `stop_seen` pulse with `is_master`=0 and `en`=1 gives a one-cycle `irq` even though `pend` does not fall.
- R10: When a set source and a clear source for `pend` occur in the same cycle, `pend` ends at 1 and no `irq` results.
- R11: A `dir_wr` strobe loads `dir` with `dir_wr_val` when no clear event or address update happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Interface enable |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| addr_cmp | input | 1 | 1 = address-compare mode (clear on match only) |
| byte_done | input | 1 | Byte sent or received, ACK clock included |
| addr_match | input | 1 | Own slave address or general-call address received |
| addr_byte | input | 1 | Any address byte received |
| arb_lost | input | 1 | Arbitration lost during a transmitted byte |
| start_seen | input | 1 | START condition detected |
| stop_seen | input | 1 | STOP condition detected |
| nack_seen | input | 1 | No ACK returned |
| start_blocked | input | 1 | START refused by the busy guard |
| rw_bit | input | 1 | R/W bit of the received address byte |
| flag_wr | input | 1 | Software write strobe for the pending flag |
| flag_wr_val | input | 1 | Value written to the pending flag |
| data_wr | input | 1 | Write to the data shift or transmit buffer register |
| dir_wr | input | 1 | Software write strobe for the direction bit |
| dir_wr_val | input | 1 | Value written to the direction bit |
| pend | output | 1 | Pending flag (1 = idle, 0 = byte finished) |
| irq | output | 1 | One-cycle interrupt request pulse |
| scl_hold | output | 1 | Request to hold SCL low and stop clock generation |
| dir | output | 1 | Transfer direction (1 = transmit, 0 = receive) |

## Verification
The assertions assume that event and write inputs are single-cycle strobes sampled on the rising edge. They also assume that no input is unknown while reset is released. The properties about clearing `pend` rule out set sources in the same cycle, so they hold for any mix of overlapping events. The bench drives every strobe for exactly one cycle, starting at a falling edge. It changes the mode inputs only while no strobe is active, and it makes set/clear overlaps only on purpose, in the priority scenario.

// File: rtl/xf_pkg.sv
package xf_pkg;

  // Pending flag next state: set sources beat clear sources.
  function automatic logic pend_next(input logic set_any, input logic clr_any,
                                     input logic cur);
    if (set_any)      return 1'b1;
    else if (clr_any) return 1'b0;
    else              return cur;
  endfunction

  // Address-phase clear of the pending flag, only in slave receive.
  function automatic logic addr_clear(input logic is_master, input logic dir,
                                      input logic cmp, input logic match,
                                      input logic any_addr);
    logic slave_rx;
    slave_rx = !is_master && !dir;
    return slave_rx && (cmp ? match : any_addr);
  endfunction

  // Bus events that force the direction back to receive.
  function automatic logic dir_clear(input logic is_master, input logic arb,
                                     input logic stop, input logic blocked,
                                     input logic start, input logic nack);
    return arb || stop || blocked || (!is_master && (start || nack));
  endfunction

endpackage

// File: rtl/xf_settle_timer.sv
module xf_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 8,
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic data_wr,
  output logic fire
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (data_wr)    cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - ONE;
  end

  // A fresh write in the final cycle restarts the wait instead of firing.
  assign fire = en && (cnt == ONE) && !data_wr;
endmodule

// File: rtl/xf_pend_flag.sv
module xf_pend_flag
  import xf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_any,
  input  logic clr_any,
  output logic pend,
  output logic fall
);
  logic pend_nxt;

  assign pend_nxt = pend_next(set_any, clr_any, pend);
  assign fall     = pend && !pend_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b1;
    else        pend <= pend_nxt;
  end
endmodule

// File: rtl/xf_dir_ctl.sv
module xf_dir_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  logic upd_val,
  input  logic wr,
  input  logic wr_val,
  output logic dir
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dir <= 1'b0;
    else if (clr) dir <= 1'b0;
    else if (upd) dir <= upd_val;
    else if (wr)  dir <= wr_val;
  end
endmodule

// File: rtl/xf_irq_gen.sv
module xf_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic slave_stop,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fall || slave_stop;
  end
endmodule

// File: rtl/i2c_xfer_flags.sv
module i2c_xfer_flags
  import xf_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic is_master,
  input  logic addr_cmp,
  input  logic byte_done,
  input  logic addr_match,
  input  logic addr_byte,
  input  logic arb_lost,
  input  logic start_seen,
  input  logic stop_seen,
  input  logic nack_seen,
  input  logic start_blocked,
  input  logic rw_bit,
  input  logic flag_wr,
  input  logic flag_wr_val,
  input  logic data_wr,
  input  logic dir_wr,
  input  logic dir_wr_val,
  output logic pend,
  output logic irq,
  output logic scl_hold,
  output logic dir
);
  // Named internal events, visible to the bound checker.
  logic settle_fire;
  logic set_any;
  logic clr_any;
  logic addr_clr;
  logic dir_clr;
  logic dir_upd;
  logic pend_fall;
  logic slave_stop;

  xf_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .data_wr (data_wr),
    .fire    (settle_fire)
  );

  assign addr_clr = addr_clear(is_master, dir, addr_cmp, addr_match, addr_byte);
  assign set_any  = !en || (flag_wr && flag_wr_val) || settle_fire;
  assign clr_any  = byte_done || arb_lost || addr_clr;

  xf_pend_flag u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_any (set_any),
    .clr_any (clr_any),
    .pend    (pend),
    .fall    (pend_fall)
  );

  assign dir_clr = dir_clear(is_master, arb_lost, stop_seen, start_blocked,
                             start_seen, nack_seen);
  assign dir_upd = !is_master && !dir && addr_cmp && addr_match;

  xf_dir_ctl u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (dir_clr),
    .upd     (dir_upd),
    .upd_val (rw_bit),
    .wr      (dir_wr),
    .wr_val  (dir_wr_val),
    .dir     (dir)
  );

  assign slave_stop = en && stop_seen && !is_master;

  xf_irq_gen u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall       (pend_fall),
    .slave_stop (slave_stop),
    .irq        (irq)
  );

  assign scl_hold = !pend;
endmodule

// File: rtl/i2c_xfer_flags_chk.sv
module i2c_xfer_flags_chk #(
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic flag_wr,
  input logic flag_wr_val,
  input logic data_wr,
  input logic byte_done,
  input logic arb_lost,
  input logic stop_seen,
  input logic pend,
  input logic irq,
  input logic scl_hold,
  input logic dir,
  input logic set_any,
  input logic slave_stop
);
  localparam int unsigned SW = $clog2(SETTLE_CYCLES + 2);
  localparam logic [SW-1:0] SAT = SW'(SETTLE_CYCLES + 1);

  // Edges since the most recent data write, saturating.
  logic [SW-1:0] since_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_wr <= SAT;
    else if (data_wr)        since_wr <= '0;
    else if (since_wr < SAT) since_wr <= since_wr + SW'(1);
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((byte_done || arb_lost) && !set_any) |=> !pend);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold != pend);

  p_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pend);

  p_swset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && flag_wr_val) |=> pend);

  p_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend) && $past(en) && !$past(flag_wr && flag_wr_val))
      |-> (since_wr >= SW'(SETTLE_CYCLES)));

  p_dirclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost || stop_seen) |=> !dir);

  p_fallirq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> irq);

  p_irqsrc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(slave_stop)) |-> $fell(pend));

  p_stopirq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slave_stop |=> irq);

  p_setwins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_any |=> pend);
endmodule

bind i2c_xfer_flags i2c_xfer_flags_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .flag_wr     (flag_wr),
  .flag_wr_val (flag_wr_val),
  .data_wr     (data_wr),
  .byte_done   (byte_done),
  .arb_lost    (arb_lost),
  .stop_seen   (stop_seen),
  .pend        (pend),
  .irq         (irq),
  .scl_hold    (scl_hold),
  .dir         (dir),
  .set_any     (set_any),
  .slave_stop  (slave_stop)
);

// File: tb/i2c_xfer_flags_test.sv
module i2c_xfer_flags_test;
  localparam int unsigned SETTLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, is_master = 1'b0, addr_cmp = 1'b1;
  logic byte_done = 0, addr_match = 0, addr_byte = 0, arb_lost = 0;
  logic start_seen = 0, stop_seen = 0, nack_seen = 0, start_blocked = 0;
  logic rw_bit = 0, flag_wr = 0, flag_wr_val = 0, data_wr = 0;
  logic dir_wr = 0, dir_wr_val = 0;
  logic pend, irq, scl_hold, dir;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  i2c_xfer_flags #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .is_master(is_master),
    .addr_cmp(addr_cmp), .byte_done(byte_done), .addr_match(addr_match),
    .addr_byte(addr_byte), .arb_lost(arb_lost), .start_seen(start_seen),
    .stop_seen(stop_seen), .nack_seen(nack_seen),
    .start_blocked(start_blocked), .rw_bit(rw_bit), .flag_wr(flag_wr),
    .flag_wr_val(flag_wr_val), .data_wr(data_wr), .dir_wr(dir_wr),
    .dir_wr_val(dir_wr_val), .pend(pend), .irq(irq), .scl_hold(scl_hold),
    .dir(dir)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic clear_strobes();
    byte_done = 0; addr_match = 0; addr_byte = 0; arb_lost = 0;
    start_seen = 0; stop_seen = 0; nack_seen = 0; start_blocked = 0;
    flag_wr = 0; flag_wr_val = 0; data_wr = 0; dir_wr = 0; dir_wr_val = 0;
  endtask

  // Strobes were set at a falling edge; end them one cycle later.
  task automatic finish_strobe();
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic release_bus();
    @(negedge clk); flag_wr = 1; flag_wr_val = 1; finish_strobe();
  endtask

  task automatic force_dir(input logic v);
    @(negedge clk); dir_wr = 1; dir_wr_val = v; finish_strobe();
  endtask

  task automatic t_reset();
    check("R3", "pend after reset", pend, 1'b1);
    check("R2", "scl_hold after reset", scl_hold, 1'b0);
    check("R7", "dir after reset", dir, 1'b0);
    check("R8", "irq after reset", irq, 1'b0);
  endtask

  task automatic t_byte_done();
    @(negedge clk); byte_done = 1; finish_strobe();
    check("R1", "pend after byte", pend, 1'b0);
    check("R2", "scl_hold while pend low", scl_hold, 1'b1);
    check("R8", "irq on fall", irq, 1'b1);
    @(negedge clk);
    check("R8", "irq is single cycle", irq, 1'b0);
    @(negedge clk); byte_done = 1; finish_strobe();
    check("R8", "no irq when already low", irq, 1'b0);
  endtask

  task automatic t_sw_write();
    @(negedge clk); flag_wr = 1; flag_wr_val = 0; finish_strobe();
    check("R3", "write 0 ignored", pend, 1'b0);
    release_bus();
    check("R3", "write 1 sets", pend, 1'b1);
    check("R2", "scl released", scl_hold, 1'b0);
  endtask

  task automatic t_settle();
    @(negedge clk); arb_lost = 1; finish_strobe();
    check("R1", "arb lost clears pend", pend, 1'b0);
    @(negedge clk); data_wr = 1; finish_strobe();
    check("R4", "pend low right after data write", pend, 1'b0);
    for (int k = 1; k < SETTLE; k++) begin
      @(negedge clk);
      check("R4", "pend low during settle", pend, 1'b0);
    end
    @(negedge clk);
    check("R4", "pend high after settle", pend, 1'b1);
    // Restart by a second write.
    @(negedge clk); byte_done = 1; finish_strobe();
    @(negedge clk); data_wr = 1; finish_strobe();
    for (int k = 1; k < 4; k++) @(negedge clk);
    data_wr = 1; finish_strobe();
    for (int k = 1; k < SETTLE; k++) @(negedge clk);
    check("R4", "restarted write still waiting", pend, 1'b0);
    @(negedge clk);
    check("R4", "pend high after restarted settle", pend, 1'b1);
  endtask

  task automatic t_addr_cmp_on();
    is_master = 0; addr_cmp = 1;
    force_dir(1'b0);
    @(negedge clk); addr_byte = 1; finish_strobe();
    check("R5", "addr_byte alone ignored in compare mode", pend, 1'b1);
    @(negedge clk); addr_match = 1; rw_bit = 1; finish_strobe();
    check("R5", "match clears pend", pend, 1'b0);
    check("R6", "rw=1 selects transmit", dir, 1'b1);
    release_bus();
    force_dir(1'b0);
    @(negedge clk); addr_match = 1; rw_bit = 0; finish_strobe();
    check("R5", "match clears pend again", pend, 1'b0);
    check("R6", "rw=0 selects receive", dir, 1'b0);
    release_bus();
  endtask

  task automatic t_addr_cmp_off();
    is_master = 0; addr_cmp = 0;
    @(negedge clk); addr_byte = 1; finish_strobe();
    check("R5", "any address clears pend", pend, 1'b0);
    release_bus();
    addr_cmp = 1; is_master = 1;
    @(negedge clk); addr_match = 1; rw_bit = 1; finish_strobe();
    check("R5", "master ignores address match", pend, 1'b1);
    check("R6", "master dir untouched by match", dir, 1'b0);
    is_master = 0;
  endtask

  task automatic t_stop();
    force_dir(1'b1);
    check("R11", "dir write 1", dir, 1'b1);
    @(negedge clk); stop_seen = 1; finish_strobe();
    check("R9", "slave stop irq", irq, 1'b1);
    check("R9", "pend stays high on stop", pend, 1'b1);
    check("R7", "stop clears dir", dir, 1'b0);
    is_master = 1;
    @(negedge clk); stop_seen = 1; finish_strobe();
    check("R9", "master stop no irq", irq, 1'b0);
    is_master = 0;
  endtask

  task automatic t_dir_clears();
    force_dir(1'b1);
    @(negedge clk); start_seen = 1; finish_strobe();
    check("R7", "slave start clears dir", dir, 1'b0);
    force_dir(1'b1);
    @(negedge clk); nack_seen = 1; finish_strobe();
    check("R7", "slave nack clears dir", dir, 1'b0);
    is_master = 1;
    force_dir(1'b1);
    @(negedge clk); start_seen = 1; nack_seen = 1; finish_strobe();
    check("R7", "master start/nack keep dir", dir, 1'b1);
    @(negedge clk); start_blocked = 1; finish_strobe();
    check("R7", "blocked start clears dir", dir, 1'b0);
    force_dir(1'b1);
    @(negedge clk); arb_lost = 1; dir_wr = 1; dir_wr_val = 1; finish_strobe();
    check("R7", "arb lost beats dir write", dir, 1'b0);
    check("R1", "arb lost clears pend", pend, 1'b0);
    release_bus();
    is_master = 0;
  endtask

  task automatic t_priority();
    @(negedge clk); byte_done = 1; flag_wr = 1; flag_wr_val = 1; finish_strobe();
    check("R10", "set beats clear", pend, 1'b1);
    check("R10", "no irq when set wins", irq, 1'b0);
    @(negedge clk); en = 0; byte_done = 1; finish_strobe();
    check("R3", "disabled forces pend", pend, 1'b1);
    check("R10", "no irq while disabled", irq, 1'b0);
    @(negedge clk); data_wr = 1; finish_strobe();
    en = 1;
    @(negedge clk); byte_done = 1; finish_strobe();
    for (int k = 0; k < SETTLE + 2; k++) @(negedge clk);
    check("R4", "disable cancelled settle", pend, 1'b0);
    release_bus();
  endtask

  initial begin
    clear_strobes();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte_done();
    t_sw_write();
    t_settle();
    t_addr_cmp_on();
    t_addr_cmp_off();
    t_stop();
    t_dir_clears();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule